// File: doc/BRIEF.md
# Address-Match ECC Error Injector

This block sits on the write path between a memory controller's ECC encoder and the DRAM interface. It corrupts stored codewords on purpose, so that the error detection and reporting logic downstream can be exercised. Each write carries a set of address fields and a 72-bit codeword (64 data bits plus 8 check bits). When injection is armed and the write's address satisfies every match field that is not set to wildcard, a flip vector is XORed into the codeword. The result goes on to memory in the same cycle, and a one-cycle done pulse is raised.

Software sets the block up through a simple register port. There are six address match registers (DIMM within channel, rank, channel, bank, page, column), each with its own wildcard bit. There is also a 64-bit corruption mask, a section selector that picks the codeword halves, a type register and an arm register. Every register reads back. A one-shot injection disarms itself after it fires. A repeating injection corrupts every matching write until software writes zero to the arm register.

Top module: `ecc_err_inject`

## Requirements
- R1: After reset the arm, type, section and both mask registers read 0, and every match register reads 0x80000000: wildcard bit 31 set, value 0.
- R2: Register map: 0 arm, 1 type, 2 section, 3 mask bits 31:0, 4 mask bits 63:32, 5..10 match registers for DIMM, rank, channel, bank, page and column. Each match register holds a wildcard bit in bit 31 and its value in the low bits, truncated to the field width (2, 2, 2, 3, 16, 12). Written values read back, and unmapped addresses read 0.
- R3: While disarmed, `mem_code` equals `wr_code` in the same cycle and `inj_done` stays low.
- R4: An armed write is corrupted only when every non-wildcard field equals the value programmed for it. A mismatch in any such field leaves the codeword unchanged.
- R5: A field whose wildcard bit is set matches any address value.
- R6: Type bit 1 (ECC) XORs mask bits 7:0 into check bits 71:64 of the codeword.
- R7: Type bit 2 (parity) XORs mask bits 63:0 into data bits 63:0. With both type bits set, both corruptions apply.
- R8: The section value limits the flips to codeword bits 35:0 (value 1), bits 71:36 (value 2), or all bits (value 3). Value 0 flips nothing, but the injection still counts: the done pulse is raised and a one-shot disarms.
- R9: When type bit 0 (repeat) is clear, a matching write disarms the block at the next clock edge, and the following matching write passes through unchanged.
- R10: When the repeat bit is set, every matching write is corrupted until zero is written to the arm register.
- R11: `inj_done` is high in exactly the cycle of a write that was injected, and the corrupted codeword appears on `mem_code` in that same cycle.
- R12: Writing any nonzero value to the arm register arms the block, and the register then reads 1.
- R13: A software write to the arm register in the same cycle as a one-shot injection takes priority over the self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| wr_valid | input | 1 | Write transaction present |
| wr_dimm | input | 2 | DIMM index within its channel |
| wr_rank | input | 2 | Rank |
| wr_chan | input | 2 | Channel |
| wr_bank | input | 3 | Bank |
| wr_page | input | 16 | Page (row) |
| wr_col | input | 12 | Column |
| wr_code | input | 72 | Encoded codeword, check bits 71:64 |
| mem_valid | output | 1 | Write forwarded to memory |
| mem_code | output | 72 | Codeword to memory, possibly corrupted |
| inj_done | output | 1 | Pulse: this write was injected |

## Verification
The bench hits the arm register with a software write in the same cycle that a one-shot injection self-clears. A design that let the self-clear win would leave the block disarmed after software re-armed it. The bench also checks one non-wildcard field at a time with a neighbouring value, which catches a comparator that ignores a field or treats a wildcard as clear. Section 0 and the two single halves each get a test, so a swapped half, or a done pulse missing when the flip vector is empty, shows up on `mem_code` or `inj_done`. Repeat mode is tested across several writes and then after a zero is written to the arm register, which catches a repeat bit that is ignored or an arm bit that never clears.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  parameter int DATA_W = 64;
  parameter int CHK_W  = 8;
  parameter int REG_W  = 32;
  parameter int ADDR_W = 4;
  parameter int NFLD   = 6;
  parameter int FLD_W  = 16;

  localparam int CW_W = DATA_W + CHK_W;
  localparam int HALF = CW_W / 2;

  localparam logic [ADDR_W-1:0] RA_ARM  = 4'd0;
  localparam logic [ADDR_W-1:0] RA_TYPE = 4'd1;
  localparam logic [ADDR_W-1:0] RA_SECT = 4'd2;
  localparam logic [ADDR_W-1:0] RA_MLO  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_MHI  = 4'd4;
  localparam int                RA_FLD0 = 5;

  localparam int TY_REP = 0;
  localparam int TY_ECC = 1;
  localparam int TY_PAR = 2;

  // field order: dimm, rank, channel, bank, page, column
  function automatic int fld_width(input int i);
    case (i)
      0, 1, 2: return 2;
      3:       return 3;
      4:       return 16;
      default: return 12;
    endcase
  endfunction

  function automatic logic [FLD_W-1:0] fld_mask(input int i);
    return FLD_W'((32'd1 << fld_width(i)) - 32'd1);
  endfunction

  // flip vector over the codeword, limited to the selected halves
  function automatic logic [CW_W-1:0] flip_vec(input logic [DATA_W-1:0] m,
                                               input logic [2:0] t,
                                               input logic [1:0] s);
    logic [CW_W-1:0] f;
    logic [CW_W-1:0] sel;
    f = '0;
    if (t[TY_ECC]) f[CW_W-1:DATA_W] = m[CHK_W-1:0];
    if (t[TY_PAR]) f[DATA_W-1:0] = m;
    sel = {{(CW_W-HALF){s[1]}}, {HALF{s[0]}}};
    return f & sel;
  endfunction
endpackage

// File: rtl/inj_regs.sv
module inj_regs
  import ecc_inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              hit,
  output logic              armed,
  output logic [2:0]        typ,
  output logic [1:0]        sect,
  output logic [DATA_W-1:0] mask,
  output logic              fld_any [NFLD],
  output logic [FLD_W-1:0]  fld_val [NFLD]
);
  logic arm_wr;
  assign arm_wr = we && (addr == RA_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      typ   <= '0;
      sect  <= '0;
      mask  <= '0;
      for (int i = 0; i < NFLD; i++) begin
        fld_any[i] <= 1'b1;
        fld_val[i] <= '0;
      end
    end else begin
      if (arm_wr)                 armed <= |wdata;
      else if (hit && !typ[TY_REP]) armed <= 1'b0;
      if (we && addr == RA_TYPE) typ  <= wdata[2:0];
      if (we && addr == RA_SECT) sect <= wdata[1:0];
      if (we && addr == RA_MLO)  mask[REG_W-1:0] <= wdata;
      if (we && addr == RA_MHI)  mask[DATA_W-1:REG_W] <= wdata;
      for (int i = 0; i < NFLD; i++) begin
        if (we && addr == ADDR_W'(RA_FLD0 + i)) begin
          fld_any[i] <= wdata[REG_W-1];
          fld_val[i] <= wdata[FLD_W-1:0] & fld_mask(i);
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_ARM)  rdata[0]   = armed;
    if (addr == RA_TYPE) rdata[2:0] = typ;
    if (addr == RA_SECT) rdata[1:0] = sect;
    if (addr == RA_MLO)  rdata      = mask[REG_W-1:0];
    if (addr == RA_MHI)  rdata      = mask[DATA_W-1:REG_W];
    for (int i = 0; i < NFLD; i++) begin
      if (addr == ADDR_W'(RA_FLD0 + i)) begin
        rdata[REG_W-1]   = fld_any[i];
        rdata[FLD_W-1:0] = fld_val[i];
      end
    end
  end

  a_r9_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !typ[TY_REP] && !arm_wr) |=> !armed);
  a_r10_repeat_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && typ[TY_REP] && !arm_wr) |=> armed);
  a_r13_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && wdata != '0) |=> armed);
endmodule

// File: rtl/inj_match.sv
module inj_match
  import ecc_inj_pkg::*;
(
  input  logic             fld_any [NFLD],
  input  logic [FLD_W-1:0] fld_val [NFLD],
  input  logic [FLD_W-1:0] addr_in [NFLD],
  output logic             all_match
);
  logic [NFLD-1:0] fld_hit;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld_hit[g] = fld_any[g] || ((addr_in[g] & fld_mask(g)) == fld_val[g]);
  end

  assign all_match = &fld_hit;

  always_comb begin
    if (fld_any[0] && fld_any[1] && fld_any[2] && fld_any[3] && fld_any[4] && fld_any[5])
      a_r5_wildcards_match: assert (all_match);
  end
endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt
  import ecc_inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              valid,
  input  logic              match,
  input  logic [DATA_W-1:0] mask,
  input  logic [2:0]        typ,
  input  logic [1:0]        sect,
  input  logic [CW_W-1:0]   code_in,
  output logic [CW_W-1:0]   code_out,
  output logic              hit
);
  logic [CW_W-1:0] flips;

  assign hit      = armed && valid && match;
  assign flips    = flip_vec(mask, typ, sect);
  assign code_out = hit ? (code_in ^ flips) : code_in;

  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (code_out == code_in));
  a_r11_done_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (armed && valid));
  a_r8_lower_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sect == 2'd1) |-> (code_out[CW_W-1:HALF] == code_in[CW_W-1:HALF]));
  a_r8_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sect == 2'd2) |-> (code_out[HALF-1:0] == code_in[HALF-1:0]));
endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject
  import ecc_inj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              wr_valid,
  input  logic [1:0]        wr_dimm,
  input  logic [1:0]        wr_rank,
  input  logic [1:0]        wr_chan,
  input  logic [2:0]        wr_bank,
  input  logic [15:0]       wr_page,
  input  logic [11:0]       wr_col,
  input  logic [CW_W-1:0]   wr_code,
  output logic              mem_valid,
  output logic [CW_W-1:0]   mem_code,
  output logic              inj_done
);
  logic              armed, match, hit;
  logic [2:0]        typ;
  logic [1:0]        sect;
  logic [DATA_W-1:0] mask;
  logic              fld_any [NFLD];
  logic [FLD_W-1:0]  fld_val [NFLD];
  logic [FLD_W-1:0]  addr_arr [NFLD];

  assign addr_arr[0] = FLD_W'(wr_dimm);
  assign addr_arr[1] = FLD_W'(wr_rank);
  assign addr_arr[2] = FLD_W'(wr_chan);
  assign addr_arr[3] = FLD_W'(wr_bank);
  assign addr_arr[4] = FLD_W'(wr_page);
  assign addr_arr[5] = FLD_W'(wr_col);

  inj_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .hit(hit), .armed(armed), .typ(typ), .sect(sect),
    .mask(mask), .fld_any(fld_any), .fld_val(fld_val)
  );

  inj_match u_match (
    .fld_any(fld_any), .fld_val(fld_val), .addr_in(addr_arr), .all_match(match)
  );

  inj_corrupt u_corrupt (
    .clk(clk), .rst_n(rst_n), .armed(armed), .valid(wr_valid), .match(match),
    .mask(mask), .typ(typ), .sect(sect), .code_in(wr_code),
    .code_out(mem_code), .hit(hit)
  );

  assign mem_valid = wr_valid;
  assign inj_done  = hit;

  a_r11_done_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    inj_done |-> mem_valid);
endmodule

// File: tb/ecc_err_inject_test.sv
module ecc_err_inject_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_dimm = '0, wr_rank = '0, wr_chan = '0;
  logic [2:0]  wr_bank = '0;
  logic [15:0] wr_page = '0;
  logic [11:0] wr_col = '0;
  logic [71:0] wr_code = '0;
  logic        mem_valid;
  logic [71:0] mem_code;
  logic        inj_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench copy of the programmed injection setup
  logic [63:0] b_mask;
  logic [2:0]  b_typ;
  logic [1:0]  b_sect;

  always #(PERIOD/2) clk = ~clk;

  ecc_err_inject uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_valid(wr_valid),
    .wr_dimm(wr_dimm), .wr_rank(wr_rank), .wr_chan(wr_chan), .wr_bank(wr_bank),
    .wr_page(wr_page), .wr_col(wr_col), .wr_code(wr_code),
    .mem_valid(mem_valid), .mem_code(mem_code), .inj_done(inj_done)
  );

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-bit statement of the corruption rules
  function automatic logic [71:0] exp_flip();
    logic [71:0] f;
    for (int i = 0; i < 72; i++) begin
      logic b;
      b = (i >= 64) ? (b_typ[1] & b_mask[i-64]) : (b_typ[2] & b_mask[i]);
      f[i] = b & ((i < 36) ? b_sect[0] : b_sect[1]);
    end
    return f;
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, 72'(reg_rdata), 72'(exp));
  endtask

  task automatic setup(input logic [2:0] t, input logic [1:0] s);
    wr_reg(4'd1, 32'(t));
    wr_reg(4'd2, 32'(s));
    b_typ = t; b_sect = s;
  endtask

  task automatic txn(input logic [1:0] d, input logic [1:0] r, input logic [1:0] c,
                     input logic [2:0] bk, input logic [15:0] pg, input logic [11:0] cl,
                     input logic [71:0] code, input bit exp_hit, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_dimm = d; wr_rank = r; wr_chan = c; wr_bank = bk;
    wr_page = pg; wr_col = cl; wr_code = code;
    #1;
    chk(req, mem_code, exp_hit ? (code ^ exp_flip()) : code);
    chk({req, " done"}, 72'(inj_done), 72'(exp_hit));
    chk({req, " valid"}, 72'(mem_valid), 72'd1);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(4'd0, 32'h0, "R1 arm");
    rd_chk(4'd1, 32'h0, "R1 type");
    rd_chk(4'd2, 32'h0, "R1 section");
    rd_chk(4'd3, 32'h0, "R1 mask lo");
    rd_chk(4'd4, 32'h0, "R1 mask hi");
    for (int i = 5; i <= 10; i++) rd_chk(4'(i), 32'h8000_0000, "R1 match");
  endtask

  task automatic t_readback;
    wr_reg(4'd1, 32'hFFFF_FFF7); rd_chk(4'd1, 32'h7, "R2 type");
    wr_reg(4'd2, 32'h3);         rd_chk(4'd2, 32'h3, "R2 section");
    wr_reg(4'd3, 32'hDEAD_BEEF); rd_chk(4'd3, 32'hDEAD_BEEF, "R2 mask lo");
    wr_reg(4'd4, 32'h0123_4567); rd_chk(4'd4, 32'h0123_4567, "R2 mask hi");
    wr_reg(4'd5, 32'h0000_00FF); rd_chk(4'd5, 32'h0000_0003, "R2 dimm trunc");
    wr_reg(4'd9, 32'h8001_2345); rd_chk(4'd9, 32'h8000_2345, "R2 page");
    wr_reg(4'd8, 32'h0000_000F); rd_chk(4'd8, 32'h0000_0007, "R2 bank trunc");
    rd_chk(4'd11, 32'h0, "R2 unmapped");
    rd_chk(4'd15, 32'h0, "R2 unmapped");
    for (int i = 5; i <= 10; i++) wr_reg(4'(i), 32'h8000_0000);
    b_mask = 64'h0123_4567_DEAD_BEEF;
  endtask

  task automatic t_disarmed;
    setup(3'b110, 2'd3);
    txn(2'd1, 2'd2, 2'd3, 3'd4, 16'h1234, 12'h567, 72'hA5_0123456789ABCDEF, 1'b0, "R3 disarmed");
  endtask

  task automatic t_oneshot;
    setup(3'b010, 2'd3);
    wr_reg(4'd0, 32'h0000_0500);
    rd_chk(4'd0, 32'h1, "R12 arm reads 1");
    txn(2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 72'h3C_FFFF0000FFFF0000, 1'b1, "R6 ecc flip");
    rd_chk(4'd0, 32'h0, "R9 disarmed");
    txn(2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 72'h3C_FFFF0000FFFF0000, 1'b0, "R9 second write");
  endtask

  task automatic t_match;
    setup(3'b011, 2'd3);
    wr_reg(4'd8, 32'h5);
    wr_reg(4'd0, 32'h1);
    txn(2'd3, 2'd1, 2'd2, 3'd4, 16'hBEEF, 12'hABC, 72'h11_2233445566778899, 1'b0, "R4 bank miss");
    txn(2'd3, 2'd1, 2'd2, 3'd5, 16'hBEEF, 12'hABC, 72'h11_2233445566778899, 1'b1, "R5 others wild");
    wr_reg(4'd5, 32'h2);
    txn(2'd1, 2'd0, 2'd0, 3'd5, 16'h0001, 12'h001, 72'h22_0000000000000001, 1'b0, "R4 dimm miss");
    txn(2'd2, 2'd3, 2'd1, 3'd5, 16'hFFFF, 12'hFFF, 72'h22_0000000000000001, 1'b1, "R4 both hit");
    wr_reg(4'd10, 32'h123);
    txn(2'd2, 2'd3, 2'd1, 3'd5, 16'hFFFF, 12'h124, 72'h22_0000000000000001, 1'b0, "R4 col miss");
    txn(2'd2, 2'd3, 2'd1, 3'd5, 16'hFFFF, 12'h123, 72'h22_0000000000000001, 1'b1, "R4 col hit");
    for (int i = 5; i <= 10; i++) wr_reg(4'(i), 32'h8000_0000);
    wr_reg(4'd0, 32'h0);
  endtask

  task automatic t_parity_repeat;
    setup(3'b101, 2'd1);
    wr_reg(4'd0, 32'h1);
    txn(2'd0, 2'd1, 2'd0, 3'd2, 16'h10, 12'h20, 72'h00_0000000000000000, 1'b1, "R8 lower half");
    setup(3'b101, 2'd2);
    txn(2'd0, 2'd1, 2'd0, 3'd2, 16'h10, 12'h20, 72'hFF_FFFFFFFFFFFFFFFF, 1'b1, "R8 upper half");
    setup(3'b101, 2'd3);
    txn(2'd0, 2'd1, 2'd0, 3'd2, 16'h10, 12'h20, 72'h5A_A5A5A5A5A5A5A5A5, 1'b1, "R7 parity both halves");
    setup(3'b111, 2'd3);
    txn(2'd1, 2'd1, 2'd1, 3'd1, 16'h11, 12'h21, 72'h00_1111111111111111, 1'b1, "R7 ecc+parity");
    rd_chk(4'd0, 32'h1, "R10 still armed");
    wr_reg(4'd0, 32'h0);
    txn(2'd1, 2'd1, 2'd1, 3'd1, 16'h11, 12'h21, 72'h00_1111111111111111, 1'b0, "R10 after disarm");
  endtask

  task automatic t_section0;
    setup(3'b010, 2'd0);
    wr_reg(4'd0, 32'h1);
    txn(2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 72'h77_7777777777777777, 1'b1, "R8 section 0 R11");
    rd_chk(4'd0, 32'h0, "R8 section 0 disarms");
  endtask

  task automatic t_collide;
    setup(3'b010, 2'd3);
    wr_reg(4'd0, 32'h1);
    @(negedge clk);
    wr_valid = 1'b1; wr_dimm = '0; wr_rank = '0; wr_chan = '0; wr_bank = '0;
    wr_page = '0; wr_col = '0; wr_code = 72'h0;
    reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1;
    #1 chk("R13 inject", 72'(inj_done), 72'd1);
    @(posedge clk);
    #1 begin wr_valid = 1'b0; reg_we = 1'b0; end
    rd_chk(4'd0, 32'h1, "R13 sw write wins");
    wr_reg(4'd0, 32'h0);
  endtask

  initial begin
    b_mask = '0; b_typ = '0; b_sect = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_readback;
    t_disarmed;
    t_oneshot;
    t_match;
    t_parity_repeat;
    t_section0;
    t_collide;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule